// File: doc/BRIEF.md
# Integer Execute Unit with Status Flags

This block is the integer execute stage of a 32-bit processor core. It takes two operands and a 4-bit operation code and returns the result in the same cycle. The operations are add, add with carry, subtract, bitwise AND/OR/XOR, three shifts, byte and halfword sign or zero extension, signed and unsigned divide, and a flag-controlled select. Three status flags sit beside the datapath in registers: carry, overflow and compare. They change only on the clock edge that closes a valid operation.

The surrounding pipeline presents one operation per cycle with `op_valid` high. It writes `result` back only when `result_we` is high. When `range_exc` is high it takes an exception. Add-type operations raise the exception only if software has set the overflow-exception enable. A divide by a zero divisor always raises it. Divide is a single-cycle behavioural operation.

Top module: `int_exec_unit`

## Requirements
- R1: ADD (code 0) returns opa+opb modulo 2^32. It sets the overflow flag when both operands have the same sign bit and the sum's sign bit differs from it, and clears the flag otherwise. Operands of opposite sign never set it.
- R2: ADD (code 0) sets the carry flag when the unsigned sum is less than opa, and clears it otherwise.
- R3: ADDC (code 1) adds the held carry flag into opa+opb and updates the overflow flag by the R1 rule. With carry-in 1, the carry flag is set when the unsigned sum is less than or equal to opa, so 0 + 0xFFFFFFFF + 1 yields 0 with carry 1. With carry-in 0 the R2 rule applies.
- R4: For ADD or ADDC, `range_exc` is high in the operation's own cycle exactly when the overflow value just computed is 1 and `ovf_exc_en` is 1.
- R5: DIVS (code 13) or DIVU (code 14) with opb equal to 0 drives `result_we` low and `range_exc` high whatever `ovf_exc_en` is. The carry flag becomes 1 at the next edge, and the overflow and compare flags keep their values.
- R6: DIVS (code 13) returns the signed quotient truncated toward zero, and DIVU (code 14) returns the unsigned quotient. With a non-zero divisor, `result_we` is high and no flag changes.
- R7: AND (code 3) with `flag_set_en` high sets the compare flag if opa&opb is zero and clears it otherwise. With `flag_set_en` low the compare flag keeps its value.
- R8: CMOV (code 15) returns opa when the compare flag is 1 and opb when it is 0.
- R9: SUB (code 2) returns opa-opb, OR (code 4) returns opa|opb and XOR (code 5) returns opa^opb. None of them changes a flag.
- R10: SLL (code 6), SRL (code 7) and SRA (code 8) shift opa by opb[4:0] only. SRA fills the vacated bits with opa[31], and SRL and SLL fill them with zeros.
- R11: EXTBS (code 9) sign-extends opa[7:0], EXTBZ (code 10) zero-extends opa[7:0], EXTHS (code 11) sign-extends opa[15:0] and EXTHZ (code 12) zero-extends opa[15:0].
- R12: Reset clears all three flags. While `op_valid` is low the flags hold, and `range_exc` and `result_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select, codes as in the requirements |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| flag_set_en | input | 1 | Lets AND update the compare flag |
| ovf_exc_en | input | 1 | Enables the exception on add overflow |
| result | output | 32 | Operation result (combinational) |
| result_we | output | 1 | Result may be written to the destination |
| range_exc | output | 1 | Range exception, for this cycle only |
| cy_flag | output | 1 | Held carry flag |
| ov_flag | output | 1 | Held overflow flag |
| f_flag | output | 1 | Held compare flag |

## Verification
The bench uses the default width of 32 bits. With that width the shifter has a 5-bit amount field. Shift amounts above 31 then reach the masking rule, and all-ones and sign-boundary operands (0x7FFFFFFF, 0x80000000, 0xFFFFFFFF) reach the carry and overflow corners of add and add-with-carry. A reference model in the bench finds the carry from a 33-bit sum and the signed quotient from magnitudes. It then compares every cycle's outputs and the flags that follow, over directed corner cases and a seeded random mix of all sixteen codes.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_SLL   = 4'd6,
    OP_SRL   = 4'd7,
    OP_SRA   = 4'd8,
    OP_EXTBS = 4'd9,
    OP_EXTBZ = 4'd10,
    OP_EXTHS = 4'd11,
    OP_EXTHZ = 4'd12,
    OP_DIVS  = 4'd13,
    OP_DIVU  = 4'd14,
    OP_CMOV  = 4'd15
  } exu_op_e;

  typedef struct packed {
    logic cy_we;
    logic cy_val;
    logic ov_we;
    logic ov_val;
    logic f_we;
    logic f_val;
  } flag_upd_t;

  function automatic logic op_is_add(input exu_op_e op);
    return (op == OP_ADD) || (op == OP_ADDC);
  endfunction

  function automatic logic op_is_div(input exu_op_e op);
    return (op == OP_DIVS) || (op == OP_DIVU);
  endfunction

  function automatic logic op_is_arith(input exu_op_e op);
    return op_is_add(op) || op_is_div(op) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/exu_arith.sv
module exu_arith
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  exu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cy_in,
  output logic [W-1:0]   res,
  output logic           cy_we,
  output logic           cy_val,
  output logic           ov_we,
  output logic           ov_val,
  output logic           div_zero,
  output logic           ovf_evt
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // Sum with optional carry-in, modulo 2^W.
  function automatic logic [W-1:0] add_sum(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic cin);
    return x + y + {{(W-1){1'b0}}, cin};
  endfunction

  // Carry rule: strict compare without carry-in, inclusive with it.
  function automatic logic add_carry(input logic [W-1:0] x, input logic [W-1:0] s,
                                     input logic cin);
    return cin ? (s <= x) : (s < x);
  endfunction

  // Signed overflow: like-signed operands, result sign flipped.
  function automatic logic add_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] s);
    return (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
  endfunction

  logic           use_cin;
  logic [W-1:0]   sum;
  logic           is_add;
  logic           is_div;
  logic [W-1:0]   divisor;
  logic [W-1:0]   quot_s;
  logic [W-1:0]   quot_u;

  assign use_cin  = (op == OP_ADDC) && cy_in;
  assign sum      = add_sum(a, b, use_cin);
  assign is_add   = op_is_add(op);
  assign is_div   = op_is_div(op);
  assign div_zero = is_div && (b == '0);
  assign ovf_evt  = is_add && add_ovf(a, b, sum);

  // A zero divisor is replaced so the behavioural divide never sees it.
  assign divisor  = (b == '0) ? ONE : b;
  assign quot_s   = W'($signed(a) / $signed(divisor));
  assign quot_u   = a / divisor;

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDC: res = sum;
      OP_SUB:          res = a - b;
      OP_DIVS:         res = quot_s;
      OP_DIVU:         res = quot_u;
      default:         res = '0;
    endcase
  end

  always_comb begin
    cy_we  = 1'b0;
    cy_val = 1'b0;
    ov_we  = 1'b0;
    ov_val = 1'b0;
    if (is_add) begin
      cy_we  = 1'b1;
      cy_val = add_carry(a, sum, use_cin);
      ov_we  = 1'b1;
      ov_val = ovf_evt;
    end else if (div_zero) begin
      cy_we  = 1'b1;
      cy_val = 1'b1;
    end
  end

endmodule

// File: rtl/exu_logic.sv
module exu_logic
  import exu_pkg::*;
#(
  parameter int W      = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  exu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           f_in,
  output logic [W-1:0]   res
);

  localparam int SH_W = $clog2(W);

  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] extend(input logic [W-1:0] v, input int n,
                                          input logic signed_ext);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = (i < n) ? v[i] : (signed_ext & v[n-1]);
    return r;
  endfunction

  // Logarithmic right shifter; a left shift runs through it bit-reversed.
  logic           shl;
  logic           fill;
  logic [W-1:0]   stage [0:SH_W];
  logic [W-1:0]   shifted;

  assign shl      = (op == OP_SLL);
  assign fill     = (op == OP_SRA) & a[W-1];
  assign stage[0] = shl ? bit_rev(a) : a;

  for (genvar s = 0; s < SH_W; s++) begin : g_shift
    localparam int D = 1 << s;
    assign stage[s+1] = b[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
  end

  assign shifted = shl ? bit_rev(stage[SH_W]) : stage[SH_W];

  always_comb begin
    unique case (op)
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_SLL,
      OP_SRL,
      OP_SRA:   res = shifted;
      OP_EXTBS: res = extend(a, BYTE_W, 1'b1);
      OP_EXTBZ: res = extend(a, BYTE_W, 1'b0);
      OP_EXTHS: res = extend(a, HALF_W, 1'b1);
      OP_EXTHZ: res = extend(a, HALF_W, 1'b0);
      OP_CMOV:  res = f_in ? a : b;
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/exu_flags.sv
module exu_flags
  import exu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      valid,
  input  flag_upd_t upd,
  output logic      cy,
  output logic      ov,
  output logic      f
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy <= 1'b0;
      ov <= 1'b0;
      f  <= 1'b0;
    end else if (valid) begin
      if (upd.cy_we) cy <= upd.cy_val;
      if (upd.ov_we) ov <= upd.ov_val;
      if (upd.f_we)  f  <= upd.f_val;
    end
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              flag_set_en,
  input  logic              ovf_exc_en,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic              range_exc,
  output logic              cy_flag,
  output logic              ov_flag,
  output logic              f_flag
);

  exu_op_e           op;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic              a_cy_we, a_cy_val, a_ov_we, a_ov_val;
  logic              div_zero;   // divide with a zero divisor this cycle
  logic              ovf_evt;    // add-type overflow computed this cycle
  logic              and_zero;
  flag_upd_t         upd;

  assign op = exu_op_e'(op_code);

  exu_arith #(.W(DATA_W)) u_arith (
    .op       (op),
    .a        (opa),
    .b        (opb),
    .cy_in    (cy_flag),
    .res      (arith_res),
    .cy_we    (a_cy_we),
    .cy_val   (a_cy_val),
    .ov_we    (a_ov_we),
    .ov_val   (a_ov_val),
    .div_zero (div_zero),
    .ovf_evt  (ovf_evt)
  );

  exu_logic #(.W(DATA_W)) u_logic (
    .op   (op),
    .a    (opa),
    .b    (opb),
    .f_in (f_flag),
    .res  (logic_res)
  );

  assign and_zero = (logic_res == '0);

  always_comb begin
    upd.cy_we  = a_cy_we;
    upd.cy_val = a_cy_val;
    upd.ov_we  = a_ov_we;
    upd.ov_val = a_ov_val;
    upd.f_we   = (op == OP_AND) && flag_set_en;
    upd.f_val  = and_zero;
  end

  exu_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (op_valid),
    .upd   (upd),
    .cy    (cy_flag),
    .ov    (ov_flag),
    .f     (f_flag)
  );

  assign result    = op_is_arith(op) ? arith_res : logic_res;
  assign result_we = op_valid && !div_zero;
  assign range_exc = op_valid && (div_zero || (ovf_evt && ovf_exc_en));

endmodule

// File: rtl/exu_checker.sv
module exu_checker
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [3:0]   op_code,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         ovf_exc_en,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic         range_exc,
  input logic         cy_flag,
  input logic         ov_flag,
  input logic         f_flag,
  input logic         div_zero,
  input logic         ovf_evt
);

  logic is_add_op, is_div_op;
  assign is_add_op = (op_code == OP_ADD) || (op_code == OP_ADDC);
  assign is_div_op = (op_code == OP_DIVS) || (op_code == OP_DIVU);

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_ADD) && (opa[W-1] != opb[W-1]) |=> !ov_flag);

  p_exc_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_add_op && !ovf_exc_en |-> !range_exc);

  p_exc_sets_ov_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_add_op && range_exc |=> ov_flag);

  p_ovf_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && ovf_evt && ovf_exc_en |-> range_exc);

  p_div0_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_div_op && (opb == '0) |-> !result_we && range_exc && div_zero);

  p_div0_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && div_zero |=> cy_flag && $stable(ov_flag) && $stable(f_flag));

  p_div_ok_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_div_op && (opb != '0) |=> $stable({cy_flag, ov_flag, f_flag}));

  p_cmov_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_CMOV) |-> result == (f_flag ? opa : opb));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !range_exc && !result_we);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({cy_flag, ov_flag, f_flag}));

endmodule

bind int_exec_unit exu_checker #(.W(DATA_W)) u_exu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .opa        (opa),
  .opb        (opb),
  .ovf_exc_en (ovf_exc_en),
  .result     (result),
  .result_we  (result_we),
  .range_exc  (range_exc),
  .cy_flag    (cy_flag),
  .ov_flag    (ov_flag),
  .f_flag     (f_flag),
  .div_zero   (div_zero),
  .ovf_evt    (ovf_evt)
);

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [31:0] opa = '0, opb = '0;
  logic        flag_set_en = 1'b0, ovf_exc_en = 1'b0;
  logic [31:0] result;
  logic        result_we, range_exc, cy_flag, ov_flag, f_flag;

  always #2 clk = ~clk;  // 250 MHz

  int_exec_unit #(.DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opa(opa), .opb(opb), .flag_set_en(flag_set_en), .ovf_exc_en(ovf_exc_en),
    .result(result), .result_we(result_we), .range_exc(range_exc),
    .cy_flag(cy_flag), .ov_flag(ov_flag), .f_flag(f_flag)
  );

  typedef struct packed {
    logic        chk_res;
    logic [31:0] res;
    logic        we;
    logic        exc;
    logic        cy;
    logic        ov;
    logic        f;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  logic  m_cy = 0, m_ov = 0, m_f = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: presents one cycle of stimulus and queues the expected outcome.
  task automatic drive(input logic v, input logic [3:0] code, input logic [31:0] a,
                       input logic [31:0] b, input logic fse, input logic exen,
                       input string tag);
    exp_t e;
    logic [32:0] s33;
    logic [31:0] r, ma, mb, q;
    logic n_cy, n_ov, n_f, ovf;
    @(negedge clk);
    op_valid = v; op_code = code; opa = a; opb = b;
    flag_set_en = fse; ovf_exc_en = exen;
    n_cy = m_cy; n_ov = m_ov; n_f = m_f;
    r = '0; ovf = 0;
    e.chk_res = v;
    e.we = v;
    case (code)
      4'd0, 4'd1: begin
        s33 = {1'b0, a} + {1'b0, b} + ((code == 4'd1) ? 33'(m_cy) : 33'd0);
        r = s33[31:0];
        n_cy = s33[32];
        ovf = (a[31] & b[31] & ~r[31]) | (~a[31] & ~b[31] & r[31]);
        n_ov = ovf;
      end
      4'd2: r = a + ~b + 32'd1;
      4'd3: begin r = a & b; if (fse) n_f = (r == 32'd0); end
      4'd4: r = a | b;
      4'd5: r = a ^ b;
      4'd6: begin r = a; repeat (int'(b[4:0])) r = {r[30:0], 1'b0}; end
      4'd7: begin r = a; repeat (int'(b[4:0])) r = {1'b0, r[31:1]}; end
      4'd8: begin r = a; repeat (int'(b[4:0])) r = {r[31], r[31:1]}; end
      4'd9:  r = {{24{a[7]}}, a[7:0]};
      4'd10: r = {24'd0, a[7:0]};
      4'd11: r = {{16{a[15]}}, a[15:0]};
      4'd12: r = {16'd0, a[15:0]};
      4'd13, 4'd14: begin
        if (b == 32'd0) begin
          n_cy = 1'b1;
          e.we = 1'b0;
          e.chk_res = 1'b0;
        end else if (code == 4'd14) begin
          r = a / b;
        end else begin
          ma = a[31] ? (~a + 32'd1) : a;
          mb = b[31] ? (~b + 32'd1) : b;
          q  = ma / mb;
          r  = (a[31] ^ b[31]) ? (~q + 32'd1) : q;
        end
      end
      default: r = m_f ? a : b;
    endcase
    e.res = r;
    e.exc = v && (((code == 4'd13 || code == 4'd14) && b == 32'd0) ||
                  ((code == 4'd0 || code == 4'd1) && ovf && exen));
    if (v) begin m_cy = n_cy; m_ov = n_ov; m_f = n_f; end
    e.cy = m_cy; e.ov = m_ov; e.f = m_f;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: combinational outputs mid-cycle, flags one cycle later.
  initial begin : monitor
    exp_t  cur, prev;
    string ctag, ptag;
    bit    have_prev = 0;
    forever begin
      @(negedge clk);
      #1;
      if (have_prev) begin
        chk(ptag, "cy_flag", {31'd0, cy_flag}, {31'd0, prev.cy});
        chk(ptag, "ov_flag", {31'd0, ov_flag}, {31'd0, prev.ov});
        chk(ptag, "f_flag",  {31'd0, f_flag},  {31'd0, prev.f});
        have_prev = 0;
      end
      if (exp_q.size() > 0) begin
        cur  = exp_q.pop_front();
        ctag = tag_q.pop_front();
        chk(ctag, "range_exc", {31'd0, range_exc}, {31'd0, cur.exc});
        chk(ctag, "result_we", {31'd0, result_we}, {31'd0, cur.we});
        if (cur.chk_res) chk(ctag, "result", result, cur.res);
        prev = cur; ptag = ctag; have_prev = 1;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stimulus
    logic [31:0] ra, rb;
    logic [3:0]  rc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset value and idle stimulus that would overflow if it counted
    drive(0, 4'd0, 32'h7fffffff, 32'h1, 1, 1, "R12");
    drive(0, 4'd13, 32'h5, 32'h0, 1, 1, "R12");
    // R1 / R2 / R4: add flags and exception gating
    drive(1, 4'd0, 32'd5, 32'd7, 0, 1, "R1");
    drive(1, 4'd0, 32'h7fffffff, 32'h1, 0, 0, "R4");
    drive(1, 4'd0, 32'h7fffffff, 32'h1, 0, 1, "R4");
    drive(1, 4'd0, 32'hffffffff, 32'h2, 0, 1, "R2");
    drive(1, 4'd0, 32'h80000000, 32'h80000000, 0, 1, "R1");
    // R3: add with carry, carry-in 1 then 0
    drive(1, 4'd1, 32'h0, 32'hffffffff, 0, 1, "R3");
    drive(1, 4'd1, 32'd3, 32'd4, 0, 1, "R3");
    drive(1, 4'd1, 32'hffffffff, 32'h0, 0, 1, "R3");
    drive(1, 4'd1, 32'h80000000, 32'hffffffff, 0, 0, "R3");
    // R9: sub and bitwise ops leave flags alone
    drive(1, 4'd2, 32'd10, 32'd3, 0, 1, "R9");
    drive(1, 4'd2, 32'd3, 32'd10, 0, 1, "R9");
    drive(1, 4'd4, 32'h00f0_0f00, 32'h0f00_00f0, 0, 0, "R9");
    drive(1, 4'd5, 32'hffff_0000, 32'h0ff0_0ff0, 0, 0, "R9");
    // R7 / R8: compare flag through AND, select through CMOV
    drive(1, 4'd3, 32'hf0, 32'h0f, 1, 0, "R7");
    drive(1, 4'd15, 32'haaaa_aaaa, 32'h5555_5555, 0, 0, "R8");
    drive(1, 4'd3, 32'hff, 32'h0f, 0, 0, "R7");
    drive(1, 4'd15, 32'h1111_1111, 32'h2222_2222, 0, 0, "R8");
    drive(1, 4'd3, 32'hff, 32'h0f, 1, 0, "R7");
    drive(1, 4'd15, 32'h1111_1111, 32'h2222_2222, 0, 0, "R8");
    // R10: shifts use opb[4:0]
    drive(1, 4'd6, 32'h1, 32'h25, 0, 0, "R10");
    drive(1, 4'd7, 32'h80000000, 32'd31, 0, 0, "R10");
    drive(1, 4'd8, 32'h80000000, 32'd4, 0, 0, "R10");
    drive(1, 4'd8, 32'h40000000, 32'h21, 0, 0, "R10");
    drive(1, 4'd7, 32'hdead_beef, 32'h20, 0, 0, "R10");
    // R11: extensions
    drive(1, 4'd9,  32'h1234_5680, 32'h0, 0, 0, "R11");
    drive(1, 4'd10, 32'h1234_5680, 32'h0, 0, 0, "R11");
    drive(1, 4'd11, 32'h0000_8001, 32'h0, 0, 0, "R11");
    drive(1, 4'd12, 32'hffff_7fff, 32'h0, 0, 0, "R11");
    // R6: divides with non-zero divisors
    drive(1, 4'd13, 32'hffff_fff9, 32'd2, 0, 1, "R6");
    drive(1, 4'd14, 32'hffff_fff9, 32'd2, 0, 1, "R6");
    drive(1, 4'd13, 32'd100, 32'hffff_fff9, 0, 1, "R6");
    // R5: divide by zero, carry cleared first
    drive(1, 4'd0, 32'd1, 32'd1, 0, 0, "R5");
    drive(1, 4'd14, 32'd77, 32'd0, 0, 0, "R5");
    drive(1, 4'd0, 32'd1, 32'd1, 0, 0, "R5");
    drive(1, 4'd13, 32'h8000_0000, 32'd0, 0, 1, "R5");
    // mixed random traffic over all codes
    for (int i = 0; i < 80; i++) begin
      rc = 4'($urandom_range(0, 15));
      ra = $urandom;
      rb = ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom;
      if (rc == 4'd13 && ra == 32'h8000_0000 && rb == 32'hffff_ffff) rb = 32'd3;
      drive(1'($urandom_range(0, 3) != 0), rc, ra, rb, 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), "R1..R12 mix");
    end
    drive(0, 4'd0, 32'h0, 32'h0, 0, 0, "R12");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule